// File: doc/BRIEF.md
# Byte-Command Register Bus Master

This block lets a host reach the registers of an attached core using nothing more than a stream of bytes. The host sends framed commands through a four-phase receive handshake. The block buffers the incoming bytes in a small queue and decodes three kinds of command: a core reset, a 32-bit register read and a 32-bit register write. It then performs the access on a simple single-cycle register bus and reports the outcome as a framed response through a separate four-phase transmit handshake.

The command frame is `0x55`, then an opcode byte, then the argument bytes, then `0xAA`. The opcodes are `0x01` for reset, `0x10` for read and `0x11` for write. A read carries a 16-bit address. A write carries a 16-bit address followed by 32 bits of data. Multi-byte fields are sent most significant byte first.

A response frame is `0xAA`, then a status byte, then any payload, then `0x55`. The status codes are:
- `0x7D`: reset done
- `0x7E`: write done
- `0x7F`: read done
- `0xFD`: the core flagged an error
- `0xFE`: the command was malformed

The engine is one state machine with seven states:
- `E_HUNT`: discards bytes until it pops `0x55`, then goes to `E_OPC`.
- `E_OPC`: pops the opcode. A reset opcode goes to `E_TAIL`. A read or write opcode goes to `E_ARG`. Any other opcode goes straight to `E_TXHI` with status `0xFE`.
- `E_ARG`: pops the address bytes, plus the data bytes for a write, then goes to `E_TAIL`.
- `E_TAIL`: pops one byte. `0xAA` goes to `E_EXEC`. Any other byte goes to `E_TXHI` with status `0xFE`.
- `E_EXEC`: drives the bus or the core reset for exactly one cycle, then goes to `E_TXHI`.
- `E_TXHI`: presents a response byte and waits for the host acknowledge to rise, then goes to `E_TXLO`.
- `E_TXLO`: waits for the acknowledge to fall. It then goes back to `E_TXHI` for the next byte, or to `E_HUNT` after the last byte.

Top module: `cmd_bus_master`

## Requirements
- R1: After reset, `tx_syn` and `rx_ack` are 0, `core_cs` is 0 and `core_rst_n` is 1.
- R2: While `rx_syn` is 1 and the 4-entry receive queue has room, the byte on `rx_data` is stored and `rx_ack` rises on the next cycle. `rx_ack` stays 1 until `rx_syn` falls. While the queue is full, `rx_ack` stays 0 until an entry is consumed.
- R3: Bytes that arrive while the engine is looking for `0x55` are discarded and produce no response and no bus activity.
- R4: The frame `55 01 AA` drives `core_rst_n` low for exactly one cycle and returns `AA 7D 55`.
- R5: The frame `55 10 Ah Al AA` raises `core_cs` for exactly one cycle with `core_we`=0 and `core_addr`={Ah,Al}. It returns `AA 7F` followed by the four bytes of `core_rdata`, most significant first, and then `55`.
- R6: The frame `55 11 Ah Al D3 D2 D1 D0 AA` raises `core_cs` for one cycle with `core_we`=1, `core_addr`={Ah,Al} and `core_wdata`={D3,D2,D1,D0}. It returns `AA 7E 55`.
- R7: If `core_err` is 1 in the cycle of a read or write access, the response is `AA FD 55` with no payload.
- R8: An opcode other than 01, 10 or 11 returns `AA FE 55` at once, with no bus access. The bytes that follow are discarded until the next `0x55`.
- R9: If the byte in the end position is not `0xAA`, the response is `AA FE 55` and no bus access or core reset takes place.
- R10: A response byte stays stable on `tx_data` with `tx_syn` high until `tx_ack` is 1. `tx_syn` falls on the cycle after `tx_ack` is seen. The next byte is not presented until `tx_ack` is 0 again.
- R11: `core_cs` and a low `core_rst_n` never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_syn | input | 1 | Host offers a command byte |
| rx_data | input | 8 | Command byte |
| rx_ack | output | 1 | Command byte taken |
| tx_syn | output | 1 | Response byte offered |
| tx_data | output | 8 | Response byte |
| tx_ack | input | 1 | Host took the response byte |
| core_rst_n | output | 1 | Active-low reset pulse to the core |
| core_cs | output | 1 | Register access strobe |
| core_we | output | 1 | Access is a write |
| core_addr | output | 16 | Register address |
| core_wdata | output | 32 | Write data |
| core_rdata | input | 32 | Read data, sampled in the access cycle |
| core_err | input | 1 | Access error, sampled in the access cycle |

## Verification
Capturing a new command byte into the queue and popping an older byte can happen in the same cycle. Receiving the next command can also overlap with the transmission of the previous response. The bench provokes both by stalling its response acknowledge while it pushes a whole second command. This fills the queue, and the bench then offers one more byte. The byte offered on a full queue must stay unacknowledged until the engine frees an entry. After the stall is released, both responses must appear intact and in order. Sweeps over every unknown opcode, a set of read and write addresses, and two acknowledge delays supply the expected bytes, which the bench computes from its own model of the core.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
    localparam logic [7:0] FRAME_SOC = 8'h55;
    localparam logic [7:0] FRAME_EOC = 8'hAA;
    localparam logic [7:0] RSP_SOR   = 8'hAA;
    localparam logic [7:0] RSP_EOR   = 8'h55;
    localparam logic [7:0] OPC_RST   = 8'h01;
    localparam logic [7:0] OPC_RD    = 8'h10;
    localparam logic [7:0] OPC_WR    = 8'h11;
    localparam logic [7:0] ST_RD_OK  = 8'h7F;
    localparam logic [7:0] ST_WR_OK  = 8'h7E;
    localparam logic [7:0] ST_RST_OK = 8'h7D;
    localparam logic [7:0] ST_UNK    = 8'hFE;
    localparam logic [7:0] ST_ERR    = 8'hFD;

    typedef enum logic [2:0] {
        E_HUNT, E_OPC, E_ARG, E_TAIL, E_EXEC, E_TXHI, E_TXLO
    } eng_state_t;
endpackage

// File: rtl/cbm_rx_port.sv
module cbm_rx_port (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_syn,
    input  logic full,
    output logic rx_ack,
    output logic push
);
    logic ack_q;

    assign push   = rx_syn && !ack_q && !full;
    assign rx_ack = ack_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ack_q <= 1'b0;
        else if (push)   ack_q <= 1'b1;
        else if (!rx_syn) ack_q <= 1'b0;
    end

    // R2: an acknowledge only ever answers an offered byte
    assert_ack_follows_syn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ack) |-> $past(rx_syn));
    // R2: a byte offered on a full queue is not acknowledged
    assert_hold_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_syn && full && !rx_ack) |=> !rx_ack);
endmodule

// File: rtl/cbm_rx_fifo.sv
module cbm_rx_fifo #(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head,
    output logic       empty,
    output logic       full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign head  = mem[rd_q];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R2: the queue never takes a byte it has no room for
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/cbm_engine.sv
module cbm_engine
    import cbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        head,
    input  logic              empty,
    output logic              pop,
    output logic              tx_syn,
    output logic [7:0]        tx_data,
    input  logic              tx_ack,
    output logic              core_rst_n,
    output logic              core_cs,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              core_err
);
    localparam int ABYTES  = ADDR_W / 8;
    localparam int DBYTES  = DATA_W / 8;
    localparam int ARGW    = ADDR_W + DATA_W;
    localparam int RSP_MAX = 3 + DBYTES;
    localparam int CW      = $clog2(ABYTES + DBYTES + 1);
    localparam int IW      = $clog2(RSP_MAX + 1);

    eng_state_t        st_q, st_d;
    logic [7:0]        opc_q, status_q;
    logic [ARGW-1:0]   arg_q;
    logic [CW-1:0]     cnt_q, need;
    logic [DATA_W-1:0] rdat_q;
    logic [IW-1:0]     idx_q, len_q;
    logic              last_byte;

    assign need      = (opc_q == OPC_WR) ? CW'(ABYTES + DBYTES) : CW'(ABYTES);
    assign last_byte = (idx_q == len_q - IW'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= E_HUNT;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_HUNT: if (!empty && head == FRAME_SOC) st_d = E_OPC;
            E_OPC: if (!empty) begin
                if (head == OPC_RST)                         st_d = E_TAIL;
                else if (head == OPC_RD || head == OPC_WR)   st_d = E_ARG;
                else                                         st_d = E_TXHI;
            end
            E_ARG:  if (!empty && cnt_q == need - CW'(1)) st_d = E_TAIL;
            E_TAIL: if (!empty) st_d = (head == FRAME_EOC) ? E_EXEC : E_TXHI;
            E_EXEC: st_d = E_TXHI;
            E_TXHI: if (tx_ack) st_d = E_TXLO;
            E_TXLO: if (!tx_ack) st_d = last_byte ? E_HUNT : E_TXHI;
            default: st_d = E_HUNT;
        endcase
    end

    // command and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opc_q    <= '0;
            status_q <= '0;
            arg_q    <= '0;
            cnt_q    <= '0;
            rdat_q   <= '0;
            idx_q    <= '0;
            len_q    <= IW'(3);
        end else begin
            unique case (st_q)
                E_OPC: if (!empty) begin
                    opc_q <= head;
                    cnt_q <= '0;
                    idx_q <= '0;
                    if (!(head == OPC_RST || head == OPC_RD || head == OPC_WR)) begin
                        status_q <= ST_UNK;
                        len_q    <= IW'(3);
                    end
                end
                E_ARG: if (!empty) begin
                    arg_q <= {arg_q[ARGW-9:0], head};
                    cnt_q <= cnt_q + 1'b1;
                end
                E_TAIL: if (!empty && head != FRAME_EOC) begin
                    status_q <= ST_UNK;
                    len_q    <= IW'(3);
                    idx_q    <= '0;
                end
                E_EXEC: begin
                    idx_q <= '0;
                    len_q <= IW'(3);
                    if (opc_q == OPC_RST)  status_q <= ST_RST_OK;
                    else if (core_err)     status_q <= ST_ERR;
                    else if (opc_q == OPC_RD) begin
                        status_q <= ST_RD_OK;
                        rdat_q   <= core_rdata;
                        len_q    <= IW'(RSP_MAX);
                    end else               status_q <= ST_WR_OK;
                end
                E_TXLO: if (!tx_ack) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        logic [DATA_W-1:0] sh;
        int                k;
        pop        = !empty && (st_q == E_HUNT || st_q == E_OPC ||
                                st_q == E_ARG  || st_q == E_TAIL);
        tx_syn     = (st_q == E_TXHI);
        core_cs    = (st_q == E_EXEC) && (opc_q != OPC_RST);
        core_we    = core_cs && (opc_q == OPC_WR);
        core_rst_n = !((st_q == E_EXEC) && (opc_q == OPC_RST));
        core_addr  = (opc_q == OPC_WR) ? arg_q[ARGW-1:DATA_W] : arg_q[ADDR_W-1:0];
        core_wdata = arg_q[DATA_W-1:0];
        k          = int'(idx_q) - 2;
        sh         = rdat_q >> (8 * (DBYTES - 1 - k));
        if (idx_q == '0)         tx_data = RSP_SOR;
        else if (last_byte)      tx_data = RSP_EOR;
        else if (idx_q == IW'(1)) tx_data = status_q;
        else                     tx_data = sh[7:0];
    end

    assert_cs_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        core_cs |=> !core_cs);
    assert_rst_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !core_rst_n |=> core_rst_n);
    assert_cs_rst_apart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_cs && !core_rst_n));
    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_syn && !tx_ack) |=> (tx_syn && $stable(tx_data)));
    assert_tx_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_syn && tx_ack) |=> !tx_syn);
endmodule

// File: rtl/cmd_bus_master.sv
module cmd_bus_master #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    parameter int RX_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_syn,
    input  logic [7:0]        rx_data,
    output logic              rx_ack,
    output logic              tx_syn,
    output logic [7:0]        tx_data,
    input  logic              tx_ack,
    output logic              core_rst_n,
    output logic              core_cs,
    output logic              core_we,
    output logic [ADDR_W-1:0] core_addr,
    output logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    input  logic              core_err
);
    logic       push, pop, empty, full;
    logic [7:0] head;

    cbm_rx_port u_port (
        .clk(clk), .rst_n(rst_n), .rx_syn(rx_syn), .full(full),
        .rx_ack(rx_ack), .push(push)
    );

    cbm_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(rx_data),
        .pop(pop), .head(head), .empty(empty), .full(full)
    );

    cbm_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .head(head), .empty(empty), .pop(pop),
        .tx_syn(tx_syn), .tx_data(tx_data), .tx_ack(tx_ack),
        .core_rst_n(core_rst_n), .core_cs(core_cs), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_err(core_err)
    );
endmodule

// File: tb/test_cmd_bus_master.sv
module test_cmd_bus_master;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        rx_syn = 1'b0, tx_ack = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_ack, tx_syn, core_rst_n, core_cs, core_we, core_err;
    logic [7:0]  tx_data;
    logic [15:0] core_addr;
    logic [31:0] core_wdata, core_rdata;

    int compared = 0, mismatched = 0;
    logic       err_en = 1'b0, hold = 1'b0;
    int         ack_dly = 0;
    logic [7:0] rlog [64];
    int         rn = 0;
    int         cs_cnt = 0, rst_cnt = 0, overlap = 0, long_cs = 0, tx_unstable = 0;
    logic       prev_cs = 1'b0;
    logic [15:0] last_addr;
    logic        last_we;
    logic [31:0] last_wdata;
    logic [7:0]  exp_b [8];

    always #4 clk = ~clk;

    function automatic logic [31:0] model_rd(input logic [15:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction
    assign core_rdata = core_cs ? model_rd(core_addr) : 32'h0;
    assign core_err   = err_en && (core_addr[15:12] == 4'hE);

    cmd_bus_master i_cmd_bus_master (
        .clk(clk), .rst_n(rst_n), .rx_syn(rx_syn), .rx_data(rx_data), .rx_ack(rx_ack),
        .tx_syn(tx_syn), .tx_data(tx_data), .tx_ack(tx_ack),
        .core_rst_n(core_rst_n), .core_cs(core_cs), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_err(core_err)
    );

    // bus monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (core_cs) begin
                cs_cnt++;
                last_addr = core_addr; last_we = core_we; last_wdata = core_wdata;
                if (prev_cs) long_cs++;
            end
            if (!core_rst_n) rst_cnt++;
            if (core_cs && !core_rst_n) overlap++;
            prev_cs = core_cs;
        end
    end

    // response receiver
    initial begin
        logic [7:0] seen;
        forever begin
            @(negedge clk);
            if (tx_syn && !hold) begin
                seen = tx_data;
                repeat (ack_dly) @(negedge clk);
                if (tx_data != seen || !tx_syn) tx_unstable++;
                if (rn < 64) rlog[rn] = tx_data;
                rn++;
                tx_ack = 1'b1;
                while (tx_syn) @(negedge clk);
                tx_ack = 1'b0;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        int t;
        @(negedge clk);
        rx_data = b; rx_syn = 1'b1;
        t = 0;
        while (!rx_ack && t < 5000) begin @(negedge clk); t++; end
        rx_syn = 1'b0;
        while (rx_ack) @(negedge clk);
    endtask

    task automatic wait_rsp(input int len);
        int t;
        t = 0;
        while (rn < len && t < 3000) begin @(negedge clk); t++; end
        repeat (20) @(negedge clk);
    endtask

    task automatic chk_rsp(input string req, input int len);
        chk({req, " length"}, rn, len);
        for (int i = 0; i < len; i++) chk(req, rlog[i], exp_b[i]);
        rn = 0;
    endtask

    task automatic set3(input logic [7:0] st);
        exp_b[0] = 8'hAA; exp_b[1] = st; exp_b[2] = 8'h55;
    endtask

    task automatic do_read(input logic [15:0] a);
        logic [31:0] d;
        int c0;
        c0 = cs_cnt;
        send_byte(8'h55); send_byte(8'h10); send_byte(a[15:8]); send_byte(a[7:0]); send_byte(8'hAA);
        d = model_rd(a);
        exp_b[0] = 8'hAA; exp_b[1] = 8'h7F;
        exp_b[2] = d[31:24]; exp_b[3] = d[23:16]; exp_b[4] = d[15:8]; exp_b[5] = d[7:0];
        exp_b[6] = 8'h55;
        wait_rsp(7);
        chk_rsp("R5 read response", 7);
        chk("R5 one access", cs_cnt - c0, 1);
        chk("R5 address", last_addr, a);
        chk("R5 write enable low", last_we, 0);
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input logic [7:0] st);
        int c0;
        c0 = cs_cnt;
        send_byte(8'h55); send_byte(8'h11); send_byte(a[15:8]); send_byte(a[7:0]);
        send_byte(d[31:24]); send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
        send_byte(8'hAA);
        set3(st);
        wait_rsp(3);
        chk_rsp("R6 write response", 3);
        chk("R6 one access", cs_cnt - c0, 1);
        chk("R6 address", last_addr, a);
        chk("R6 write enable high", last_we, 1);
        chk("R6 data", last_wdata, d);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        int c0, r0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 tx_syn", tx_syn, 0);
        chk("R1 rx_ack", rx_ack, 0);
        chk("R1 core_cs", core_cs, 0);
        chk("R1 core_rst_n", core_rst_n, 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R4 reset command
        r0 = rst_cnt;
        send_byte(8'h55); send_byte(8'h01); send_byte(8'hAA);
        set3(8'h7D); wait_rsp(3);
        chk_rsp("R4 reset response", 3);
        chk("R4 one-cycle core reset", rst_cnt - r0, 1);

        // R5/R6 sweeps with two acknowledge delays (R10)
        for (int dl = 0; dl < 2; dl++) begin
            ack_dly = dl * 5;
            for (int a = 0; a < 16; a++) do_read(16'(a * 16'h1111 + dl));
            for (int a = 0; a < 16; a++)
                do_write(16'(a * 16'h0F0F), 32'(a * 32'h01010101) ^ 32'hDEAD0000, 8'h7E);
        end
        ack_dly = 1;

        // R7 core error on read and write
        err_en = 1'b1;
        c0 = cs_cnt;
        send_byte(8'h55); send_byte(8'h10); send_byte(8'hE1); send_byte(8'h23); send_byte(8'hAA);
        set3(8'hFD); wait_rsp(3);
        chk_rsp("R7 read error", 3);
        do_write(16'hE000, 32'h12345678, 8'hFD);
        err_en = 1'b0;

        // R8 every unknown opcode
        c0 = cs_cnt; r0 = rst_cnt;
        for (int op = 0; op < 256; op++) begin
            if (op == 8'h01 || op == 8'h10 || op == 8'h11) continue;
            send_byte(8'h55); send_byte(8'(op)); send_byte(8'hAA);
            set3(8'hFE); wait_rsp(3);
            chk_rsp("R8 unknown opcode", 3);
        end
        chk("R8 no access", cs_cnt - c0, 0);
        chk("R8 no reset", rst_cnt - r0, 0);

        // R9 wrong end byte
        c0 = cs_cnt;
        send_byte(8'h55); send_byte(8'h10); send_byte(8'h12); send_byte(8'h34); send_byte(8'h00);
        set3(8'hFE); wait_rsp(3);
        chk_rsp("R9 missing end byte", 3);
        chk("R9 no access", cs_cnt - c0, 0);
        r0 = rst_cnt;
        send_byte(8'h55); send_byte(8'h01); send_byte(8'h55);
        set3(8'hFE); wait_rsp(3);
        chk_rsp("R9 reset without end byte", 3);
        chk("R9 no reset", rst_cnt - r0, 0);

        // R3 garbage before a frame is discarded
        c0 = cs_cnt;
        send_byte(8'h00); send_byte(8'hAA); send_byte(8'h11); send_byte(8'h10);
        wait_rsp(1);
        chk("R3 no response to garbage", rn, 0);
        chk("R3 no access on garbage", cs_cnt - c0, 0);
        do_read(16'h0042);

        // R2 full queue while the response is stalled
        hold = 1'b1;
        send_byte(8'h55); send_byte(8'h10); send_byte(8'h00); send_byte(8'h42); send_byte(8'hAA);
        send_byte(8'h55); send_byte(8'h10); send_byte(8'h00); send_byte(8'h05);
        @(negedge clk);
        rx_data = 8'hAA; rx_syn = 1'b1;
        repeat (12) @(negedge clk);
        chk("R2 no ack while full", rx_ack, 0);
        hold = 1'b0;
        begin
            int t;
            t = 0;
            while (!rx_ack && t < 3000) begin @(negedge clk); t++; end
        end
        chk("R2 ack once space frees", rx_ack, 1);
        rx_syn = 1'b0;
        while (rx_ack) @(negedge clk);
        wait_rsp(14);
        chk("R2 both responses", rn, 14);
        chk("R2 first status", rlog[1], 8'h7F);
        chk("R2 first data low", rlog[5], 8'h42);
        chk("R2 second status", rlog[8], 8'h7F);
        chk("R2 second data low", rlog[12], 8'h05);
        chk("R2 second end", rlog[13], 8'h55);
        rn = 0;

        // R10 / R11 / R5 running tallies
        chk("R10 tx byte held until ack", tx_unstable, 0);
        chk("R11 access and reset apart", overlap, 0);
        chk("R5 single-cycle strobe", long_cs, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule